// File: doc/BRIEF.md
# Single-data-rate ninth-bit transfer engine

This block is the bit-level core of a serial target on a two-wire bus. It works from a synchronous view of the clock and data lines, together with START and STOP pulses from a separate detector. It drives the data line through an enable and a value. Every byte takes nine clocks: eight data bits, most significant first, and then a ninth bit. The engine decides what that ninth bit means for the current byte. For the address byte, and for every byte of a legacy-compatible message, it is an acknowledge. For native write bytes after the address it is odd parity, which the engine checks. For native read bytes it is an end-of-data or continue flag. The target drives that flag and releases it early, so the controller can abort the read.

Written bytes leave on a strobe-only stream (`wr_valid`, `wr_data`). There is no back-pressure on that stream: the bus clock cannot be stalled, so the sink must accept every strobe. Read bytes enter on a valid/ready stream. `rd_ready` is high for exactly one cycle when the engine loads the next byte. A byte is taken when `rd_valid` and `rd_ready` are both high. Once `rd_valid` is raised it must stay high, with `rd_data` steady, until the byte is taken. The engine uses the state of `rd_valid` to decide between ending and continuing a read.

Top module: `sdr9_target`

## Requirements
- R1: A byte is eight data bits followed by one ninth bit, so exactly nine SCL rising edges make one byte. The bus is sampled on SCL rising edges, and the target changes its drive only in the cycle it sees an SCL falling edge. The exception is a release at a rising edge.
- R2: The address byte is seven address bits followed by a direction bit in bit 0 (1 = read).
  - When the address equals `TARGET_ADDR` and the byte is a write, the target drives 0 in the ninth bit and releases at the ninth rising edge.
  - When the address matches and the byte is a read with `rd_valid` high, the target drives 0 in the ninth bit and keeps driving into the data.
  - Otherwise the target does not drive at all, and ignores the bus until the next START.
- R3: In a native write, each data byte produces a one-cycle `wr_valid` pulse with `wr_data` just after its ninth rising edge. `wr_par_err` is high in the same cycle when the byte plus its ninth bit hold an even number of ones. The target never drives during these bytes.
- R4: In a legacy-compatible write (`legacy_msg` high at the address acknowledge), the target drives 0 in the ninth bit of each data byte. No parity check is made, so `wr_par_err` stays 0.
- R5: In a native read, the target sends bytes most significant bit first. In the ninth bit it drives 1 when `rd_valid` is high, and otherwise drives 0 and pulses `rd_end`. In both cases it releases SDA at the ninth rising edge.
- R6: `rd_ready` is high for one cycle, at the SCL falling edge that starts bit 7 of each read byte, which is one cycle before that bit is driven. Exactly one byte is taken per read byte sent.
- R7: SDA seen low while SCL is high in the released continue bit of a native read is a controller abort. The engine then pulses `rd_abort`, takes no further byte, stays released, and waits for a new address as after a repeated START.
- R8: In a legacy read, the target releases SDA in the ninth bit. The controller driving 0 there means continue. Driving 1 ends the read with an `rd_end` pulse. A continued byte with `rd_valid` low is sent as all ones.
- R9: `start_det` restarts the bit count, releases SDA and expects an address byte. `stop_det` releases SDA and idles the engine.
- R10: After reset, `sda_drv_en`, `wr_valid`, `wr_par_err`, `rd_ready`, `rd_end` and `rd_abort` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-cycle START or repeated START pulse |
| stop_det | input | 1 | One-cycle STOP pulse |
| legacy_msg | input | 1 | Current message is legacy-compatible; sampled at the address acknowledge |
| sda_drv_en | output | 1 | Target drives SDA |
| sda_drv_val | output | 1 | Level driven when enabled |
| wr_data | output | DATA_BITS | Received write byte |
| wr_valid | output | 1 | Write byte strobe |
| wr_par_err | output | 1 | Parity mismatch on the strobed byte |
| rd_data | input | DATA_BITS | Next read byte |
| rd_valid | input | 1 | Read byte available |
| rd_ready | output | 1 | Read byte being taken |
| rd_end | output | 1 | Read finished strobe |
| rd_abort | output | 1 | Controller aborted the read strobe |

## Verification
The hardest case to reach is the controller abort. It exists only inside the released high phase of a continue bit. That phase lasts a few system cycles and occurs only after a native read has sent a byte with more data queued. The stimulus builds a read with several bytes queued and lets one byte go out. During the ninth bit, after the target releases at the rising edge, it pulls SDA low while SCL is still high. The bench then checks that no further byte is fetched and that a fresh address is needed. Parity errors, end-of-data on random-length reads, and read underrun in legacy mode are driven from seeded random data.

// File: rtl/sdr9_pkg.sv
package sdr9_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_t;
endpackage

// File: rtl/sdr9_edge.sv
module sdr9_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_in;
  end

  assign scl_rise = scl_in & ~scl_q;
  assign scl_fall = ~scl_in & scl_q;
endmodule

// File: rtl/sdr9_bitcnt.sv
module sdr9_bitcnt #(
  parameter int DATA_BITS = 8,
  localparam int CW = $clog2(DATA_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          scl_rise,
  output logic [CW-1:0] cnt,
  output logic          first
);
  localparam logic [CW-1:0] LAST = CW'(DATA_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (restart) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (scl_rise) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        first <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr9_rx.sv
module sdr9_rx #(
  parameter int DATA_BITS = 8,
  localparam int CW = $clog2(DATA_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic [CW-1:0]        cnt,
  input  logic                 sda_in,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 par_ok
);
  logic [DATA_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else if (scl_rise && cnt < CW'(DATA_BITS)) sh <= {sh[DATA_BITS-2:0], sda_in};
  end

  assign rx_byte = sh;
  // odd parity: byte plus ninth bit must hold an odd number of ones
  assign par_ok  = ^{sh, sda_in};
endmodule

// File: rtl/sdr9_target.sv
module sdr9_target
  import sdr9_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int unsigned TARGET_ADDR = 32'h2A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 legacy_msg,
  output logic                 sda_drv_en,
  output logic                 sda_drv_val,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 wr_valid,
  output logic                 wr_par_err,
  input  logic [DATA_BITS-1:0] rd_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  output logic                 rd_end,
  output logic                 rd_abort
);
  localparam int CW     = $clog2(DATA_BITS + 1);
  localparam int ADDR_W = DATA_BITS - 1;
  localparam logic [CW-1:0]     LAST = CW'(DATA_BITS);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(TARGET_ADDR);

  logic                 scl_rise, scl_fall;
  logic [CW-1:0]        cnt;
  logic                 first;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 par_ok;

  phase_t               phase;
  logic                 leg_q, arm, watch;
  logic [DATA_BITS-1:0] tx_sh;

  logic abort_now, fetch, ninth_rise, addr_hit, dir_rd;

  assign abort_now  = watch & scl_in & ~sda_in;
  assign ninth_rise = scl_rise && (cnt == LAST);
  assign addr_hit   = (rx_byte[DATA_BITS-1:1] == MY_ADDR);
  assign dir_rd     = rx_byte[0];
  assign fetch      = scl_fall && (phase == PH_READ) && arm && (cnt == '0)
                      && !start_det && !stop_det;
  assign rd_ready   = fetch;

  sdr9_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  sdr9_bitcnt #(.DATA_BITS(DATA_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(start_det | abort_now),
    .scl_rise(scl_rise), .cnt(cnt), .first(first)
  );

  sdr9_rx #(.DATA_BITS(DATA_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .cnt(cnt),
    .sda_in(sda_in), .rx_byte(rx_byte), .par_ok(par_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      leg_q       <= 1'b0;
      arm         <= 1'b0;
      watch       <= 1'b0;
      tx_sh       <= '0;
      sda_drv_en  <= 1'b0;
      sda_drv_val <= 1'b1;
      wr_data     <= '0;
      wr_valid    <= 1'b0;
      wr_par_err  <= 1'b0;
      rd_end      <= 1'b0;
      rd_abort    <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      wr_par_err <= 1'b0;
      rd_end     <= 1'b0;
      rd_abort   <= 1'b0;
      if (stop_det) begin
        phase      <= PH_IDLE;
        sda_drv_en <= 1'b0;
        arm        <= 1'b0;
        watch      <= 1'b0;
      end else if (start_det || abort_now) begin
        phase      <= PH_ADDR;
        sda_drv_en <= 1'b0;
        arm        <= 1'b0;
        watch      <= 1'b0;
        rd_abort   <= abort_now;
      end else begin
        if (scl_fall) begin
          watch <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (cnt == LAST) begin
                if (addr_hit && (!dir_rd || rd_valid)) begin
                  sda_drv_en  <= 1'b1;
                  sda_drv_val <= 1'b0;
                  leg_q       <= legacy_msg;
                  arm         <= dir_rd;
                  phase       <= dir_rd ? PH_READ : PH_WRITE;
                end else begin
                  phase <= PH_IDLE;
                end
              end
            end
            PH_WRITE: begin
              if (cnt == LAST && leg_q) begin
                sda_drv_en  <= 1'b1;
                sda_drv_val <= 1'b0;
              end
            end
            PH_READ: begin
              if (cnt == '0) begin
                if (arm) begin
                  arm        <= 1'b0;
                  sda_drv_en <= 1'b1;
                  if (rd_valid) begin
                    sda_drv_val <= rd_data[DATA_BITS-1];
                    tx_sh       <= {rd_data[DATA_BITS-2:0], 1'b0};
                  end else begin
                    sda_drv_val <= 1'b1;
                    tx_sh       <= '1;
                  end
                end
              end else if (cnt < LAST) begin
                sda_drv_val <= tx_sh[DATA_BITS-1];
                tx_sh       <= {tx_sh[DATA_BITS-2:0], 1'b1};
              end else if (leg_q) begin
                sda_drv_en <= 1'b0;
              end else if (rd_valid) begin
                sda_drv_val <= 1'b1;
                arm         <= 1'b1;
              end else begin
                sda_drv_val <= 1'b0;
                rd_end      <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (ninth_rise) begin
          if (!(phase == PH_READ && first)) sda_drv_en <= 1'b0;
          if (phase == PH_WRITE && !first) begin
            wr_valid   <= 1'b1;
            wr_data    <= rx_byte;
            wr_par_err <= !leg_q && !par_ok;
          end
          if (phase == PH_READ && !first) begin
            if (leg_q) begin
              if (sda_in) begin
                rd_end <= 1'b1;
                phase  <= PH_IDLE;
              end else begin
                arm <= 1'b1;
              end
            end else if (arm) begin
              watch <= 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdr9_target_chk.sv
module sdr9_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_drv_en,
  input logic sda_drv_val,
  input logic wr_valid,
  input logic wr_par_err,
  input logic rd_ready,
  input logic rd_end,
  input logic rd_abort
);
  // R1: driven value changes only after a cycle with SCL low
  a_r1_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drv_en && $past(sda_drv_en) && (sda_drv_val != $past(sda_drv_val))) |-> !$past(scl_in));

  // R1: the target starts driving only in SCL low phase
  a_r1_drive_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drv_en) |-> !$past(scl_in));

  a_r3_parity_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_par_err |-> wr_valid);

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r5_end_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && sda_drv_en) |-> !sda_drv_val);

  a_r6_fetch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !scl_in);

  a_r7_abort_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abort |-> !sda_drv_en);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, rd_end, rd_abort}));
endmodule

bind sdr9_target sdr9_target_chk u_sdr9_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
  .sda_drv_en(sda_drv_en), .sda_drv_val(sda_drv_val),
  .wr_valid(wr_valid), .wr_par_err(wr_par_err),
  .rd_ready(rd_ready), .rd_end(rd_end), .rd_abort(rd_abort)
);

// File: tb/test_sdr9_target.sv
module test_sdr9_target;
  localparam logic [6:0] TADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl = 1'b1, ctl_en = 1'b0, ctl_v = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0, legacy = 1'b0;
  logic drv_en, drv_val, wr_valid, wr_par_err, rd_valid, rd_ready, rd_end, rd_abort;
  logic [7:0] wr_data, rd_data;
  logic sda;

  assign sda = (ctl_en ? ctl_v : 1'b1) & (drv_en ? drv_val : 1'b1);

  logic [7:0] rd_mem [16];
  int rd_idx = 0;
  int rd_n = 0;
  assign rd_valid = rd_idx < rd_n;
  assign rd_data  = rd_mem[rd_idx[3:0]];
  always @(posedge clk) if (rd_ready && rd_valid) rd_idx <= rd_idx + 1;

  sdr9_target i_sdr9_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .start_det(start_det), .stop_det(stop_det), .legacy_msg(legacy),
    .sda_drv_en(drv_en), .sda_drv_val(drv_val),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_par_err(wr_par_err),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_end(rd_end), .rd_abort(rd_abort)
  );

  int n_wr = 0, n_par = 0, n_end = 0, n_abort = 0;
  logic [7:0] last_wr = '0;
  always @(negedge clk) begin
    if (wr_valid) begin n_wr++; last_wr = wr_data; if (wr_par_err) n_par++; end
    if (rd_end) n_end++;
    if (rd_abort) n_abort++;
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic bitc(input logic d_en, input logic d_v,
                      output logic lo_en, output logic lo_val, output logic hi_en);
    scl = 1'b0;
    repeat (2) @(negedge clk);
    ctl_en = d_en; ctl_v = d_v;
    repeat (2) @(negedge clk);
    lo_en = drv_en; lo_val = drv_val;
    scl = 1'b1;
    repeat (2) @(negedge clk);
    hi_en = drv_en;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_start();
    ctl_en = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    ctl_en = 1'b1; ctl_v = 1'b0; start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_stop();
    scl = 1'b0; ctl_en = 1'b1; ctl_v = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    ctl_en = 1'b0; stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rd,
                           output logic e, output logic v, output logic h);
    logic [7:0] b;
    logic x0, x1, x2;
    b = {a, rd};
    for (int i = 7; i >= 0; i--) bitc(1'b1, b[i], x0, x1, x2);
    bitc(1'b0, 1'b0, e, v, h);
  endtask

  task automatic send_data(input logic [7:0] b);
    logic x0, x1, x2;
    for (int i = 7; i >= 0; i--) bitc(1'b1, b[i], x0, x1, x2);
  endtask

  task automatic recv_data(output logic [7:0] got, output bit all_en);
    logic e, v, h;
    all_en = 1;
    for (int i = 7; i >= 0; i--) begin
      bitc(1'b0, 1'b0, e, v, h);
      got[i] = v;
      if (!e) all_en = 0;
    end
  endtask

  task automatic load_rd(input int k);
    for (int j = 0; j < k; j++) rd_mem[(rd_idx + j) % 16] = 8'($urandom);
    rd_n = rd_idx + k;
  endtask

  initial begin
    logic e, v, h;
    logic [7:0] b, got;
    bit all_en, bad;
    int w0, p0, e0, a0, base, k;
    void'($urandom(32'd11));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!drv_en && !wr_valid && !wr_par_err && !rd_ready && !rd_end && !rd_abort,
        "R10 reset outputs", {drv_en, wr_valid, rd_ready, rd_end}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // native write with random parity faults
    do_start();
    send_addr(TADDR, 1'b0, e, v, h);
    chk(e && !v, "R2 write address ack driven low", {e, v}, 2);
    chk(!h, "R2 write ack released at rise", h, 0);
    w0 = n_wr;
    for (int n = 0; n < 6; n++) begin
      b = 8'($urandom);
      bad = ($urandom % 3) == 0;
      p0 = n_par;
      send_data(b);
      bitc(1'b1, odd_bit(b) ^ bad, e, v, h);
      chk(!e, "R3 target silent in parity bit", e, 0);
      chk(last_wr == b, "R3 write data", last_wr, b);
      chk((n_par - p0) == int'(bad), "R3 parity flag", n_par - p0, bad);
    end
    chk((n_wr - w0) == 6, "R1 nine clocks per byte", n_wr - w0, 6);
    do_stop();

    // address mismatch
    do_start();
    send_addr(TADDR ^ 7'h01, 1'b0, e, v, h);
    chk(!e, "R2 mismatch not acked", e, 0);
    w0 = n_wr;
    send_data(8'h5A);
    bitc(1'b1, 1'b0, e, v, h);
    chk(n_wr == w0 && !e, "R2 mismatch ignored", n_wr - w0, 0);
    do_stop();

    // legacy write: ack per byte, no parity
    legacy = 1'b1;
    do_start();
    send_addr(TADDR, 1'b0, e, v, h);
    legacy = 1'b0;
    for (int n = 0; n < 3; n++) begin
      b = 8'($urandom);
      w0 = n_wr; p0 = n_par;
      send_data(b);
      bitc(1'b0, 1'b0, e, v, h);
      chk(e && !v, "R4 legacy write ack", {e, v}, 2);
      chk((n_wr - w0) == 1 && n_par == p0 && last_wr == b, "R4 no parity check",
          n_par - p0, 0);
    end
    do_stop();

    // native reads of random length
    for (int r = 0; r < 3; r++) begin
      k = 1 + int'($urandom % 4);
      base = rd_idx;
      load_rd(k);
      do_start();
      send_addr(TADDR, 1'b1, e, v, h);
      chk(e && !v && h, "R2 read ack held into data", {e, v, h}, 5);
      for (int j = 0; j < k; j++) begin
        e0 = n_end;
        recv_data(got, all_en);
        chk(all_en && got == rd_mem[(base + j) % 16], "R5 read byte", got, rd_mem[(base + j) % 16]);
        chk(rd_idx == base + j + 1, "R6 one fetch per byte", rd_idx - base, j + 1);
        bitc(1'b0, 1'b0, e, v, h);
        chk(e && v == (j < k - 1), "R5 ninth bit end/continue", v, int'(j < k - 1));
        chk(!h, "R5 released at ninth rise", h, 0);
        chk((n_end - e0) == int'(j == k - 1), "R5 rd_end strobe", n_end - e0, int'(j == k - 1));
      end
      do_stop();
    end

    // read with nothing queued
    rd_n = rd_idx;
    do_start();
    send_addr(TADDR, 1'b1, e, v, h);
    chk(!e, "R2 read without data not acked", e, 0);
    do_stop();

    // controller abort in the continue bit
    base = rd_idx;
    load_rd(3);
    do_start();
    send_addr(TADDR, 1'b1, e, v, h);
    recv_data(got, all_en);
    chk(got == rd_mem[base % 16], "R5 byte before abort", got, rd_mem[base % 16]);
    a0 = n_abort;
    scl = 1'b0;
    repeat (2) @(negedge clk);
    ctl_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(drv_en && drv_val, "R7 continue driven high", {drv_en, drv_val}, 3);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    ctl_en = 1'b1; ctl_v = 1'b0;
    repeat (3) @(negedge clk);
    chk((n_abort - a0) == 1, "R7 abort strobe", n_abort - a0, 1);
    start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    send_addr(TADDR ^ 7'h04, 1'b1, e, v, h);
    chk(!e && rd_idx == base + 1, "R7 no fetch after abort", rd_idx - base, 1);
    do_stop();

    // legacy read: controller acks, underrun gives ones
    base = rd_idx;
    load_rd(2);
    legacy = 1'b1;
    do_start();
    send_addr(TADDR, 1'b1, e, v, h);
    legacy = 1'b0;
    for (int j = 0; j < 2; j++) begin
      recv_data(got, all_en);
      chk(got == rd_mem[(base + j) % 16], "R8 legacy read byte", got, rd_mem[(base + j) % 16]);
      bitc(1'b1, 1'b0, e, v, h);
      chk(!e, "R8 target released in ninth", e, 0);
    end
    recv_data(got, all_en);
    chk(got == 8'hFF, "R8 underrun sends ones", got, 8'hFF);
    e0 = n_end;
    bitc(1'b1, 1'b1, e, v, h);
    chk((n_end - e0) == 1, "R8 controller ends read", n_end - e0, 1);
    do_stop();

    // repeated START mid-byte restarts the count
    do_start();
    send_addr(TADDR, 1'b0, e, v, h);
    for (int i = 0; i < 3; i++) bitc(1'b1, 1'b1, e, v, h);
    do_start();
    send_addr(TADDR, 1'b0, e, v, h);
    chk(e && !v, "R9 repeated START realigns address", {e, v}, 2);
    w0 = n_wr;
    send_data(8'hC3);
    bitc(1'b1, odd_bit(8'hC3), e, v, h);
    chk((n_wr - w0) == 1 && last_wr == 8'hC3, "R9 data after restart", last_wr, 8'hC3);
    load_rd(1);
    do_start();
    send_addr(TADDR, 1'b1, e, v, h);
    do_stop();
    chk(!drv_en, "R9 STOP releases SDA", drv_en, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule